// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out the memory traffic of subroutine entry and exit for a 32-bit processor core. It is handed the current program counter, frame pointer, stack pointer and call target together with an operation code. It then runs two word accesses on a simple request/ready memory port and hands back the new program counter, frame pointer and stack pointer, marked by a one-cycle done pulse. The register file stays outside the block. The core writes the three results back when it sees the pulse.

A call frame is always three words. Below the incoming stack pointer sits an empty word reserved for a static-chain link. Under that word is the return address, and under that is the caller's frame pointer. The stack pointer and the frame pointer both end up pointing at the saved frame pointer. A return works from the frame pointer alone. It reloads the caller's frame pointer and the return address from the frame, then places the stack pointer just above the static-chain word.

Memory is byte addressed and each word is stored with its most significant byte at the lowest address. On the port this means data bits [31:24] belong to the byte at the word's own address.

Top module: `frame_sequencer`

## Requirements
- R1: After reset, busy, memReq, memWrite and donePulse are 0, and newPc, newFp and newSp are 0.
- R2: For a call, the first access writes the return address to curSp-8 and the second writes curFp to curSp-12. memWrite is 1 on both accesses, and the word at curSp-4 is never touched.
- R3: The return address is curPc+6 when opKind is 2'b01 (call with absolute 32-bit target) and curPc+2 when opKind is 2'b10 (call through a register).
- R4: After a call, newSp and newFp both equal curSp-12 and newPc equals target.
- R5: For a return (opKind 2'b11), the first access reads curFp and the second reads curFp+4, with memWrite 0. newFp is the word read at curFp, newPc is the word read at curFp+4, and newSp is curFp+12. curSp and target have no effect.
- R6: Each access holds memReq, memAddr, memWdata and memWrite steady until a cycle with memReady high. The sequence advances only on such a handshake, so every wait cycle adds exactly one cycle.
- R7: donePulse is high for exactly one cycle, the cycle after the second handshake. newPc, newFp and newSp are valid in that cycle and hold until the next completed operation. With w wait cycles per access, donePulse comes 2w+2 cycles after the first request cycle.
- R8: While busy is 1, startValid is ignored. Exactly two accesses occur per accepted operation, and the results are those of the accepted operation.
- R9: Words are big-endian. memWdata[31:24] is written to the byte at memAddr, and memRdata[31:24] is taken as the byte at memAddr.
- R10: startValid with opKind 2'b00 is ignored. No access is made, busy stays 0, and the results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start an operation (taken only while idle) |
| opKind | input | 2 | 00 none, 01 absolute call, 10 register call, 11 return |
| curPc | input | 32 | Address of the call instruction |
| curFp | input | 32 | Current frame pointer |
| curSp | input | 32 | Current stack pointer |
| target | input | 32 | Call destination |
| busy | output | 1 | Operation in progress |
| memReq | output | 1 | Memory access request |
| memWrite | output | 1 | Access is a write |
| memAddr | output | 32 | Byte address of the word |
| memWdata | output | 32 | Write data, big-endian |
| memRdata | input | 32 | Read data, valid with memReady |
| memReady | input | 1 | Access completes this cycle |
| newPc | output | 32 | Resulting program counter |
| newFp | output | 32 | Resulting frame pointer |
| newSp | output | 32 | Resulting stack pointer |
| donePulse | output | 1 | One-cycle completion strobe |

## Verification
Both call forms are run with different wait-state counts. Because they differ only in the return-address offset, the stored return word separates a +6 design from a +2 design. The wait counts catch a sequencer that advances without a handshake or gets its completion cycle wrong. A return is run against a frame preloaded with byte-distinct words while curSp and target carry unrelated values. This exposes a byte-order swap, a read-order swap, and any stack pointer derived from curSp instead of curFp. A call followed by a return on the frame it built must restore the caller's pointers and step over the static-chain word. Holding startValid with a different opcode during a busy sequence, and pulsing the "none" opcode, show that neither one leaks into the accesses or the results.

// File: rtl/frame_seq_pkg.sv
`timescale 1ns/1ps
package frame_seq_pkg;
  typedef enum logic [1:0] {
    OP_NONE     = 2'b00,
    OP_CALL_ABS = 2'b01,
    OP_CALL_REG = 2'b10,
    OP_RETURN   = 2'b11
  } frame_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FIRST,
    ST_SECOND,
    ST_FINISH
  } seq_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;          // capture operands
    logic second;        // second access is active
    logic captureFirst;  // first access handshake
    logic commit;        // second access handshake
  } seq_strobe_t;

  // Instruction lengths that set the return address
  localparam int unsigned ABS_CALL_BYTES = 6;
  localparam int unsigned REG_CALL_BYTES = 2;
endpackage

// File: rtl/frame_seq_ctrl.sv
`timescale 1ns/1ps
module frame_seq_ctrl
  import frame_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic [1:0]  opKind,
  input  logic        memReady,
  output logic        busy,
  output logic        memReq,
  output logic        donePulse,
  output seq_strobe_t strb
);
  seq_state_e state, stateNext;
  logic accept;
  logic handshake;

  assign accept    = (state == ST_IDLE) && startValid && (opKind != OP_NONE);
  assign memReq    = (state == ST_FIRST) || (state == ST_SECOND);
  assign handshake = memReq && memReady;
  assign busy      = (state != ST_IDLE);
  assign donePulse = (state == ST_FINISH);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (accept) stateNext = ST_FIRST;
      ST_FIRST:  if (handshake) stateNext = ST_SECOND;
      ST_SECOND: if (handshake) stateNext = ST_FINISH;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.load         = accept;
    strb.second       = (state == ST_SECOND);
    strb.captureFirst = (state == ST_FIRST) && handshake;
    strb.commit       = (state == ST_SECOND) && handshake;
  end

  // R6: an access without ready keeps requesting
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq);
  // R7: done lasts one cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);
  // R7: done follows a completed access
  assert_done_after_access_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(donePulse) |-> $past(memReq && memReady));
endmodule

// File: rtl/frame_seq_dp.sv
`timescale 1ns/1ps
module frame_seq_dp
  import frame_seq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  seq_strobe_t     strb,
  input  logic            accessActive,
  input  logic [1:0]      opKind,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] curFp,
  input  logic [XLEN-1:0] curSp,
  input  logic [XLEN-1:0] target,
  input  logic [XLEN-1:0] memRdata,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  output logic            memWrite,
  output logic [XLEN-1:0] newPc,
  output logic [XLEN-1:0] newFp,
  output logic [XLEN-1:0] newSp
);
  localparam int unsigned WORD_BYTES = XLEN / 8;
  localparam logic [XLEN-1:0] ONE_WORD   = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] TWO_WORDS  = XLEN'(2 * WORD_BYTES);
  localparam logic [XLEN-1:0] FRAME_SIZE = XLEN'(3 * WORD_BYTES);

  logic            isCall;
  logic [XLEN-1:0] baseReg;    // sp for call, fp for return
  logic [XLEN-1:0] retReg;
  logic [XLEN-1:0] savedFp;
  logic [XLEN-1:0] tgtReg;
  logic [XLEN-1:0] firstWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isCall  <= 1'b0;
      baseReg <= '0;
      retReg  <= '0;
      savedFp <= '0;
      tgtReg  <= '0;
    end else if (strb.load) begin
      isCall  <= (opKind != OP_RETURN);
      baseReg <= (opKind == OP_RETURN) ? curFp : curSp;
      retReg  <= curPc + ((opKind == OP_CALL_ABS) ? XLEN'(ABS_CALL_BYTES)
                                                  : XLEN'(REG_CALL_BYTES));
      savedFp <= curFp;
      tgtReg  <= target;
    end
  end

  // Access address and data for the two steps
  always_comb begin
    if (isCall) begin
      memAddr  = strb.second ? (baseReg - FRAME_SIZE) : (baseReg - TWO_WORDS);
      memWdata = strb.second ? savedFp : retReg;
    end else begin
      memAddr  = strb.second ? (baseReg + ONE_WORD) : baseReg;
      memWdata = '0;
    end
    memWrite = accessActive && isCall;
  end

  always_ff @(posedge clk) begin
    if (!rstN) firstWord <= '0;
    else if (strb.captureFirst) firstWord <= memRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newPc <= '0;
      newFp <= '0;
      newSp <= '0;
    end else if (strb.commit) begin
      if (isCall) begin
        newPc <= tgtReg;
        newFp <= baseReg - FRAME_SIZE;
        newSp <= baseReg - FRAME_SIZE;
      end else begin
        newPc <= memRdata;
        newFp <= firstWord;
        newSp <= baseReg + FRAME_SIZE;
      end
    end
  end

  // R2: the second call access is one word below the first
  assert_call_descend_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.captureFirst && isCall |=> memAddr == $past(memAddr) - ONE_WORD);
endmodule

// File: rtl/frame_sequencer.sv
`timescale 1ns/1ps
module frame_sequencer
  import frame_seq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startValid,
  input  logic [1:0]      opKind,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] curFp,
  input  logic [XLEN-1:0] curSp,
  input  logic [XLEN-1:0] target,
  output logic            busy,
  output logic            memReq,
  output logic            memWrite,
  output logic [XLEN-1:0] memAddr,
  output logic [XLEN-1:0] memWdata,
  input  logic [XLEN-1:0] memRdata,
  input  logic            memReady,
  output logic [XLEN-1:0] newPc,
  output logic [XLEN-1:0] newFp,
  output logic [XLEN-1:0] newSp,
  output logic            donePulse
);
  seq_strobe_t strb;

  frame_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opKind(opKind),
    .memReady(memReady), .busy(busy), .memReq(memReq),
    .donePulse(donePulse), .strb(strb)
  );

  frame_seq_dp #(.XLEN(XLEN)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .accessActive(memReq),
    .opKind(opKind), .curPc(curPc), .curFp(curFp), .curSp(curSp),
    .target(target), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memWrite(memWrite), .newPc(newPc),
    .newFp(newFp), .newSp(newSp)
  );

  // R6: a stalled access keeps address, data and direction
  assert_access_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> $stable(memAddr) && $stable(memWdata) && $stable(memWrite));
  // R8/R10: an idle block makes no access
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !memWrite);
endmodule

// File: tb/test_frame_sequencer.sv
`timescale 1ns/1ps
module test_frame_sequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [1:0]  opKind = 2'b00;
  logic [31:0] curPc = '0, curFp = '0, curSp = '0, target = '0;
  logic        busy, memReq, memWrite, memReady, donePulse;
  logic [31:0] memAddr, memWdata, memRdata, newPc, newFp, newSp;

  int checks = 0;
  int fails = 0;

  logic [7:0]  mem [0:255];
  logic [31:0] logAddr [0:7];
  logic [31:0] logData [0:7];
  logic        logWr [0:7];
  int          logCount = 0;
  int          waitSet = 0;
  int          waitCnt = 0;

  always #4 clk = ~clk;

  frame_sequencer i_frame_sequencer (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opKind(opKind),
    .curPc(curPc), .curFp(curFp), .curSp(curSp), .target(target),
    .busy(busy), .memReq(memReq), .memWrite(memWrite), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .newPc(newPc), .newFp(newFp), .newSp(newSp), .donePulse(donePulse)
  );

  // Big-endian byte memory model with programmable wait states
  assign memReady = memReq && (waitCnt >= waitSet);
  assign memRdata = {mem[memAddr[7:0]], mem[memAddr[7:0] + 8'd1],
                     mem[memAddr[7:0] + 8'd2], mem[memAddr[7:0] + 8'd3]};

  always @(posedge clk) begin
    if (memReq && !memReady) waitCnt <= waitCnt + 1;
    else waitCnt <= 0;
    if (memReq && memReady) begin
      if (logCount < 8) begin
        logAddr[logCount] <= memAddr;
        logData[logCount] <= memWrite ? memWdata : memRdata;
        logWr[logCount]   <= memWrite;
      end
      logCount <= logCount + 1;
      if (memWrite) begin
        mem[memAddr[7:0]]         <= memWdata[31:24];
        mem[memAddr[7:0] + 8'd1]  <= memWdata[23:16];
        mem[memAddr[7:0] + 8'd2]  <= memWdata[15:8];
        mem[memAddr[7:0] + 8'd3]  <= memWdata[7:0];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic putWord(input logic [7:0] a, input logic [31:0] w);
    mem[a] = w[31:24]; mem[a + 8'd1] = w[23:16];
    mem[a + 8'd2] = w[15:8]; mem[a + 8'd3] = w[7:0];
  endtask

  // Start one operation, return cycles from first request cycle to done
  task automatic runOp(input logic [1:0] op, input logic [31:0] pc, fp, sp, tgt,
                       input int waits, input bit holdStart, output int cycles);
    @(negedge clk);
    waitSet = waits;
    logCount = 0;
    opKind = op; curPc = pc; curFp = fp; curSp = sp; target = tgt;
    startValid = 1'b1;
    @(negedge clk);
    if (holdStart) begin
      opKind = 2'b11; curFp = 32'h10; curSp = 32'h20; target = 32'h30;
    end else startValid = 1'b0;
    cycles = 0;
    while (!donePulse && cycles < 100) begin
      @(negedge clk);
      cycles++;
    end
    startValid = 1'b0;
  endtask

  task automatic testReset();
    check(busy == 0 && memReq == 0 && memWrite == 0 && donePulse == 0,
          "R1 control outputs idle", {busy, memReq, memWrite, donePulse}, 0);
    check(newPc == 0 && newFp == 0 && newSp == 0, "R1 results zero", newPc | newFp | newSp, 0);
  endtask

  task automatic testCallAbs();
    int cyc;
    runOp(2'b01, 32'h12345670, 32'h00000060, 32'h00000080, 32'h00002000, 0, 0, cyc);
    check(cyc == 2, "R7 done timing w=0", cyc, 2);
    check(newPc == 32'h2000, "R4 newPc", newPc, 32'h2000);
    check(newSp == 32'h74 && newFp == 32'h74, "R4 newSp/newFp", newSp ^ newFp ^ 32'h74, 32'h74);
    @(negedge clk);
    check(donePulse == 0, "R7 single pulse", donePulse, 0);
    check(logCount == 2, "R2 access count", logCount, 2);
    check(logAddr[0] == 32'h78 && logWr[0], "R2 first address", logAddr[0], 32'h78);
    check(logData[0] == 32'h12345676, "R3 absolute return address", logData[0], 32'h12345676);
    check(logAddr[1] == 32'h74 && logWr[1], "R2 second address", logAddr[1], 32'h74);
    check(logData[1] == 32'h60, "R2 saved fp", logData[1], 32'h60);
    check(mem[8'h78] == 8'h12 && mem[8'h7B] == 8'h76, "R9 big-endian store",
          {mem[8'h78], mem[8'h7B]}, 16'h1276);
    check(mem[8'h7C] == 8'hEE, "R2 static-chain slot untouched", mem[8'h7C], 8'hEE);
  endtask

  task automatic testCallReg();
    int cyc;
    runOp(2'b10, 32'hABCD0010, 32'h000000B0, 32'h000000C0, 32'h00005554, 2, 0, cyc);
    check(cyc == 6, "R6 wait states add cycles", cyc, 6);
    check(logData[0] == 32'hABCD0012, "R3 register-call return address", logData[0], 32'hABCD0012);
    check(logAddr[0] == 32'hB8 && logAddr[1] == 32'hB4, "R2 addresses with waits",
          logAddr[0] ^ logAddr[1], 32'hB8 ^ 32'hB4);
    check(newPc == 32'h5554 && newSp == 32'hB4 && newFp == 32'hB4, "R4 register call results",
          newSp, 32'hB4);
  endtask

  task automatic testReturn();
    int cyc;
    @(negedge clk);
    putWord(8'h40, 32'hCAFE0041);
    putWord(8'h44, 32'h00001234);
    runOp(2'b11, 32'h0, 32'h00000040, 32'h00000999, 32'h77777777, 1, 0, cyc);
    check(cyc == 4, "R7 return timing w=1", cyc, 4);
    check(logAddr[0] == 32'h40 && !logWr[0], "R5 first read at fp", logAddr[0], 32'h40);
    check(logAddr[1] == 32'h44 && !logWr[1], "R5 second read at fp+4", logAddr[1], 32'h44);
    check(newFp == 32'hCAFE0041, "R9 big-endian load of fp", newFp, 32'hCAFE0041);
    check(newPc == 32'h1234, "R5 newPc", newPc, 32'h1234);
    check(newSp == 32'h4C, "R5 newSp from fp", newSp, 32'h4C);
  endtask

  task automatic testRoundTrip();
    int cyc;
    runOp(2'b01, 32'h00000500, 32'h000000E0, 32'h000000F0, 32'h00000900, 1, 0, cyc);
    check(newFp == 32'hE4, "R4 round-trip call fp", newFp, 32'hE4);
    runOp(2'b11, 32'h00000900, newFp, newSp, 32'h0, 0, 0, cyc);
    check(newFp == 32'hE0, "R5 restored fp", newFp, 32'hE0);
    check(newPc == 32'h506, "R5 restored return address", newPc, 32'h506);
    check(newSp == 32'hF0, "R5 sp past static chain", newSp, 32'hF0);
  endtask

  task automatic testBusyIgnore();
    int cyc;
    runOp(2'b10, 32'h00000300, 32'h00000020, 32'h000000A0, 32'h00000444, 1, 1, cyc);
    check(newPc == 32'h444 && newSp == 32'h94, "R8 results of accepted op", newSp, 32'h94);
    repeat (3) @(negedge clk);
    check(logCount == 2, "R8 no extra accesses", logCount, 2);
    check(busy == 0, "R8 back to idle", busy, 0);
  endtask

  task automatic testNoneOp();
    bit sawBusy = 0;
    logic [31:0] pcBefore = newPc;
    @(negedge clk);
    logCount = 0;
    opKind = 2'b00; curSp = 32'h50; startValid = 1'b1;
    repeat (4) begin
      @(negedge clk);
      if (busy || memReq) sawBusy = 1;
    end
    startValid = 1'b0;
    check(!sawBusy, "R10 none op stays idle", sawBusy, 0);
    check(logCount == 0 && newPc == pcBefore, "R10 no access, results kept", logCount, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCallAbs();
    testCallReg();
    testReturn();
    testRoundTrip();
    testBusyIgnore();
    testNoneOp();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule